// File: doc/BRIEF.md
# Write Byte-Enable to Memory Data-Mask Converter

This block sits on the write path between a full-rate local port and a memory data bus half as wide. Each accepted local beat carries a 32-bit word, a 4-bit byte-enable (high means "write this byte") and a word address. The block turns it into two consecutive memory-side beats of 16 data bits each, with a 2-bit data mask where a high bit means "do not write this byte".

The local side is a valid/ready stream. The memory side is a valid-only stream that carries one beat per clock, so it runs at twice the local beat rate. A flag marks the first beat of each pair. The address that came with the word is held on both beats.

The width of the local word address is derived from the memory geometry: bank bits plus row bits plus column bits, less three, plus the bits needed to select a rank when there is more than one rank.

Top module: `be_dm_converter`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is low and `in_ready` is high.
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both high. Its first memory beat appears in the next cycle, with `out_valid` and `out_first` both high.
- R3: The first beat of a word carries data bits [15:0] on `out_dq`. Its mask comes from byte-enables [1:0].
- R4: In the cycle after the first beat, the second beat carries data bits [31:16] with `out_first` low. Its mask comes from byte-enables [3:2].
- R5: Each mask bit is the inverse of its byte-enable bit. `out_dm[0]` covers `out_dq[7:0]` and `out_dm[1]` covers `out_dq[15:8]`. For example, enables 4'b1100 give mask 2'b11 on the first beat and 2'b00 on the second.
- R6: `in_ready` is low while a first beat is on the output and high otherwise. Words presented back to back therefore give an unbroken run of memory beats.
- R7: A byte whose enable is low still drives its data bits unchanged. Only its mask bit marks it.
- R8: The local address width is BANK_W + ROW_W + COL_W - 3, plus ceil(log2(RANKS)) when RANKS > 1. With 2, 13 and 10 bits and one rank this gives 22. `out_addr` shows the accepted address on both beats of its word.
- R9: No memory beat is produced unless a word has been accepted, and each accepted word produces exactly two beats. `in_valid` held high while `in_ready` is low is not taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Local beat offered |
| in_ready | output | 1 | Converter can take a local beat |
| in_data | input | 32 | Local write word |
| in_be | input | 4 | Byte enables, active high, bit i for byte i |
| in_addr | input | LADDR_W (22) | Local word address |
| out_valid | output | 1 | Memory beat present |
| out_first | output | 1 | High on the first (lower-half) beat of a word |
| out_dq | output | 16 | Memory write data |
| out_dm | output | 2 | Data mask, active low enable (high masks the byte) |
| out_addr | output | LADDR_W (22) | Address of the word being emitted |

## Verification
A phase register stuck or stepping wrongly shows on the very next cycle. The order of halves is swapped, a beat is repeated or dropped, or `in_ready` opens too early, and the scoreboard sees a mismatched or extra beat at once. A lost polarity inversion or a crossed lane shows on the first beat whose enables are not uniform, so the bench uses asymmetric patterns such as 1100, 0110 and 1010. A held-word register that is overwritten too early corrupts the second beat one cycle after acceptance. A broken back-to-back handoff shows as a gap in the beat run during the streaming test.

// File: rtl/be_dm_pkg.sv
package be_dm_pkg;

    parameter int unsigned LCL_W  = 32;
    parameter int unsigned MEM_W  = 16;
    parameter int unsigned BYTE_W = 8;

    localparam int unsigned RATIO     = LCL_W / MEM_W;
    localparam int unsigned LCL_BYTES = LCL_W / BYTE_W;
    localparam int unsigned MEM_BYTES = MEM_W / BYTE_W;
    localparam int unsigned PHASE_W   = (RATIO > 1) ? $clog2(RATIO) : 1;

    typedef struct packed {
        logic [LCL_W-1:0]     data;
        logic [LCL_BYTES-1:0] be;
    } lcl_beat_t;

    typedef struct packed {
        logic [MEM_W-1:0]     dq;
        logic [MEM_BYTES-1:0] dm;
    } mem_beat_t;

    function automatic int unsigned rank_sel_bits(input int unsigned ranks);
        return (ranks > 1) ? $clog2(ranks) : 0;
    endfunction

    function automatic int unsigned local_addr_bits(input int unsigned bank_w,
                                                    input int unsigned row_w,
                                                    input int unsigned col_w,
                                                    input int unsigned ranks);
        return bank_w + row_w + col_w - 3 + rank_sel_bits(ranks);
    endfunction

endpackage

// File: rtl/be_dm_lane_map.sv
module be_dm_lane_map
    import be_dm_pkg::*;
(
    input  logic [MEM_W-1:0]     lane_data,
    input  logic [MEM_BYTES-1:0] lane_be,
    output mem_beat_t            beat
);
    genvar g;
    generate
        for (g = 0; g < MEM_BYTES; g++) begin : g_lane
            assign beat.dq[g*BYTE_W +: BYTE_W] = lane_data[g*BYTE_W +: BYTE_W];
            assign beat.dm[g]                  = ~lane_be[g];
        end
    endgenerate
endmodule

// File: rtl/be_dm_serializer.sv
module be_dm_serializer
    import be_dm_pkg::*;
#(
    parameter int unsigned AW = 22
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  lcl_beat_t            in_word,
    input  logic [AW-1:0]        in_addr,
    output logic                 sel_valid,
    output logic                 sel_first,
    output logic [MEM_W-1:0]     sel_data,
    output logic [MEM_BYTES-1:0] sel_be,
    output logic [AW-1:0]        sel_addr
);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(RATIO - 1);

    lcl_beat_t          word_q;
    logic [AW-1:0]      addr_q;
    logic [PHASE_W-1:0] phase_q;
    logic               valid_q;
    logic               last;
    logic               accept;

    logic [MEM_W-1:0]     dslice [RATIO];
    logic [MEM_BYTES-1:0] bslice [RATIO];

    genvar g;
    generate
        for (g = 0; g < RATIO; g++) begin : g_slice
            assign dslice[g] = word_q.data[g*MEM_W +: MEM_W];
            assign bslice[g] = word_q.be[g*MEM_BYTES +: MEM_BYTES];
        end
    endgenerate

    assign last     = (phase_q == LAST_PHASE);
    assign in_ready = !valid_q || last;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            addr_q  <= '0;
            phase_q <= '0;
            valid_q <= 1'b0;
        end else if (accept) begin
            word_q  <= in_word;
            addr_q  <= in_addr;
            phase_q <= '0;
            valid_q <= 1'b1;
        end else if (valid_q) begin
            if (last) begin
                valid_q <= 1'b0;
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign sel_valid = valid_q;
    assign sel_first = valid_q && (phase_q == '0);
    assign sel_data  = dslice[phase_q];
    assign sel_be    = bslice[phase_q];
    assign sel_addr  = addr_q;

    // R2: an accepted word starts at phase zero in the next cycle
    p_start_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (valid_q && phase_q == '0));

    // R4: the held word stays put until its last beat has gone out
    p_word_held_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !last) |=> (valid_q && $stable(word_q)));
endmodule

// File: rtl/be_dm_converter.sv
module be_dm_converter
    import be_dm_pkg::*;
#(
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned RANKS  = 1,
    localparam int unsigned LADDR_W = local_addr_bits(BANK_W, ROW_W, COL_W, RANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [LCL_W-1:0]     in_data,
    input  logic [LCL_BYTES-1:0] in_be,
    input  logic [LADDR_W-1:0]   in_addr,
    output logic                 out_valid,
    output logic                 out_first,
    output logic [MEM_W-1:0]     out_dq,
    output logic [MEM_BYTES-1:0] out_dm,
    output logic [LADDR_W-1:0]   out_addr
);
    lcl_beat_t            in_word;
    logic [MEM_W-1:0]     sel_data;
    logic [MEM_BYTES-1:0] sel_be;
    mem_beat_t            mbeat;

    assign in_word.data = in_data;
    assign in_word.be   = in_be;

    be_dm_serializer #(.AW(LADDR_W)) ser_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_word  (in_word),
        .in_addr  (in_addr),
        .sel_valid(out_valid),
        .sel_first(out_first),
        .sel_data (sel_data),
        .sel_be   (sel_be),
        .sel_addr (out_addr)
    );

    be_dm_lane_map map_i (
        .lane_data(sel_data),
        .lane_be  (sel_be),
        .beat     (mbeat)
    );

    assign out_dq = mbeat.dq;
    assign out_dm = mbeat.dm;

    // R3: the first beat carries the lower half of the word taken one cycle earlier
    p_lower_half_first_r3: assert property (@(posedge clk) disable iff (rst)
        out_first |-> (out_dq == $past(in_data[MEM_W-1:0])));

    // R5: the first beat's mask is the inverse of the lower enables
    p_mask_inverted_r5: assert property (@(posedge clk) disable iff (rst)
        out_first |-> (out_dm == ~$past(in_be[MEM_BYTES-1:0])));

    // R6: no new word is taken while a first beat is on the output
    p_ready_low_mid_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_first) |-> !in_ready);

    // R8: the address stays the same across the beats of one word
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_first) |-> (out_addr == $past(out_addr)));
endmodule

// File: tb/be_dm_converter_tb.sv
`timescale 1ns/1ps
module be_dm_converter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be = '0;
    logic [21:0] in_addr = '0;
    logic        out_valid;
    logic        out_first;
    logic [15:0] out_dq;
    logic [1:0]  out_dm;
    logic [21:0] out_addr;

    always #2.5 clk = ~clk;

    be_dm_converter dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_be(in_be), .in_addr(in_addr),
        .out_valid(out_valid), .out_first(out_first),
        .out_dq(out_dq), .out_dm(out_dm), .out_addr(out_addr)
    );

    typedef struct packed {
        logic [15:0] dq;
        logic [1:0]  dm;
        logic [21:0] addr;
        logic        first;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int run_len = 0;
    int max_run = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: called at a falling edge
    task automatic send(input logic [31:0] d, input logic [3:0] b, input logic [21:0] a);
        exp_t e;
        in_valid = 1'b1; in_data = d; in_be = b; in_addr = a;
        while (!in_ready) @(negedge clk);
        e.dq = d[15:0];  e.dm = ~b[1:0]; e.addr = a; e.first = 1'b1; exp_q.push_back(e);
        e.dq = d[31:16]; e.dm = ~b[3:2]; e.addr = a; e.first = 1'b0; exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
                // R6: ready is low on a first beat, high on the last one
                check(in_ready == !out_first, "R6", "in_ready", 32'(in_ready), 32'(!out_first));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected beat", 32'(out_dq), 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_first == e.first, "R2", "out_first", 32'(out_first), 32'(e.first));
                    // R7: disabled bytes still carry their data
                    check(out_dq == e.dq, e.first ? "R3" : "R4", "out_dq", 32'(out_dq), 32'(e.dq));
                    check(out_dm == e.dm, "R5", "out_dm", 32'(out_dm), 32'(e.dm));
                    check(out_addr == e.addr, "R8", "out_addr", 32'(out_addr), 32'(e.addr));
                end
            end else begin
                run_len = 0;
                check(in_ready == 1'b1, "R6", "in_ready idle", 32'(in_ready), 32'h1);
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state seen while reset is still asserted and just after release
        check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);
        // R8: geometry-derived address width
        check(dut_i.LADDR_W == 22, "R8", "address width", 32'(dut_i.LADDR_W), 32'd22);

        // R5: asymmetric enable patterns, with gaps between words
        send(32'h22334455, 4'b1100, 22'h000001);
        repeat (3) @(negedge clk);
        send(32'h667788AA, 4'b0110, 22'h000002);
        repeat (2) @(negedge clk);
        send(32'hBBCCDDEE, 4'b1010, 22'h3FFFFF);
        repeat (3) @(negedge clk);
        // R7: all bytes disabled, data still driven
        send(32'hDEADBEEF, 4'b0000, 22'h155555);
        send(32'hFFFFFFFF, 4'b1111, 22'h2AAAAA);
        repeat (4) @(negedge clk);

        // R6: back-to-back stream with no gaps
        max_run = 0;
        for (int i = 0; i < 8; i++)
            send(32'h01020304 * (i + 1), 4'(i * 5 + 3), 22'(i * 97));
        repeat (4) @(negedge clk);
        check(max_run >= 16, "R6", "unbroken beat run", 32'(max_run), 32'd16);

        // R9: held valid while busy is not taken twice; idle stays quiet
        for (int i = 0; i < 20; i++) begin
            send(32'hA5A50000 + 32'(i), 4'(i), 22'(i));
            if (i % 3 == 0) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R9", "beats outstanding", 32'(exp_q.size()), 32'h0);
        check(out_valid == 1'b0, "R9", "idle out_valid", 32'(out_valid), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule